// File: doc/BRIEF.md
# PME Root Status Register

This block is the 32-bit root-port status word that records power-management-event messages arriving from downstream requesters. Each incoming event carries a 16-bit requester ID. When no event is being reported, an arriving event is reported straight away. The block sets a status flag and shows that event's requester ID in the low half of the register.

Events that arrive while the status flag is set are not lost. They are queued in a small hold FIFO, and a pending flag shows that a backlog exists. Software acknowledges the reported event by writing 1 to the status bit. If the queue holds anything, hardware then reports the oldest held event at once: the status stays set and the ID changes.

When the queue is full, a further event is discarded and a sticky drop indicator is raised. An interrupt line follows the status flag. Message decode, the link layer and the interrupt controller sit outside this block.

Top module: `pme_root_status`

## Requirements
- R1: After reset the whole register reads 0x00000000, and both `irq` and `pme_drop_seen` are 0.
- R2: Register bits 31:18 always read 0, and writes to them have no effect.
- R3: If an event arrives (`pme_valid`=1) while status (bit 16) is 0, the next cycle shows bit 16 = 1 and bits 15:0 = that event's requester ID.
- R4: Writing 1 to bit 16 while status is set, with nothing held and no event arriving, makes bit 16 read 0 in the next cycle. Bits 15:0 keep the last reported ID. Writing 0 to bit 16 has no effect.
- R5: An event that arrives while status is set is held. Status stays 1 and bits 15:0 do not change.
- R6: Bit 17 (pending) reads 1 exactly when at least one held event is waiting. It is never 1 while bit 16 is 0.
- R7: Writing 1 to bit 16 while events are held reports the oldest held event in the next cycle: bit 16 stays 1 and bits 15:0 take its ID. Held events come out in arrival order.
- R8: Up to 4 events can be held. An event that arrives while 4 are held is dropped. Status, ID and the held queue stay unchanged, and `pme_drop_seen` goes to 1 and stays 1 until reset.
- R9: If a clear (write 1 to bit 16) and a new event land in the same cycle with nothing held, the new event is reported directly. Bit 16 stays 1 and bits 15:0 take the new ID.
- R10: `irq` equals bit 16 in every cycle.
- R11: If a clear and a new event land in the same cycle while events are held, the oldest held event is reported and the new event joins the back of the queue. This also applies when the queue was full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pme_valid | input | 1 | An event message is present this cycle |
| pme_req_id | input | 16 | Requester ID of the event message |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data (bit 16 = write-1-to-clear status) |
| reg_rdata | output | 32 | Current register value |
| irq | output | 1 | Interrupt request, high while status is set |
| pme_drop_seen | output | 1 | Sticky flag: an event was dropped because the queue was full |

## Verification
The hardest situation to reach is a clear landing in the same cycle as a new event while the hold queue is full. In that cycle one entry leaves the queue and one enters it, and the arrival must be accepted rather than dropped. The stimulus reaches this state by sending five back-to-back events after reset: one is reported and four are held. It then issues a combined clear-and-event write and drains the queue one clear at a time, so that each delivered ID can be checked against the arrival order. A sweep over 0 to 6 back-to-back arrivals covers the empty, partly filled, full and overflow cases.

// File: rtl/pme_pkg.sv
// Package: shared layout constants for the event root status register.
// Assumes: register is 32 bits; status and pending bit positions are fixed
// because software decodes them.
package pme_pkg;
    localparam int REG_W    = 32;
    localparam int ID_W     = 16;
    localparam int STS_BIT  = 16;
    localparam int PEND_BIT = 17;
    localparam int RSVD_W   = REG_W - PEND_BIT - 1;
endpackage

// File: rtl/pme_hold_fifo.sv
// Module: pme_hold_fifo
// Holds requester IDs of events waiting to be reported, oldest first.
// Assumes: the caller never pops when empty. It may push when full only
// in the same cycle as a pop.
module pme_hold_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    // Advance a pointer, wrapping at the last slot.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // One storage slot per entry, written when the write pointer selects it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (push && wr_ptr == PW'(g))
                mem[g] <= din;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Head of queue and flags.
    always_comb begin
        dout  = mem[rd_ptr];
        empty = (count == '0);
        full  = (count == CNT_FULL);
    end
endmodule

// File: rtl/pme_report_ctrl.sv
// Module: pme_report_ctrl
// Decides, each cycle, whether an event is reported, held, dropped or
// delivered from the queue, and keeps the status flag and reported ID.
// Assumes: the queue is empty whenever status is clear.
module pme_report_ctrl #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt_valid,
    input  logic [W-1:0] evt_id,
    input  logic         clr_req,
    input  logic         q_empty,
    input  logic         q_full,
    input  logic [W-1:0] q_head,
    output logic         q_push,
    output logic         q_pop,
    output logic         status,
    output logic [W-1:0] cur_id,
    output logic         dropped
);
    logic         status_d;
    logic [W-1:0] id_d;
    logic         drop_now;
    logic         clr;

    // Next-state decision for status, ID and queue actions.
    always_comb begin
        clr      = clr_req && status;
        status_d = status;
        id_d     = cur_id;
        q_push   = 1'b0;
        q_pop    = 1'b0;
        drop_now = 1'b0;
        if (!status) begin
            if (evt_valid) begin
                status_d = 1'b1;
                id_d     = evt_id;
            end
        end else if (clr) begin
            if (!q_empty) begin
                q_pop  = 1'b1;
                id_d   = q_head;
                q_push = evt_valid;
            end else if (evt_valid) begin
                id_d = evt_id;
            end else begin
                status_d = 1'b0;
            end
        end else if (evt_valid) begin
            if (!q_full)
                q_push = 1'b1;
            else
                drop_now = 1'b1;
        end
    end

    // Status, reported ID and sticky drop state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status  <= 1'b0;
            cur_id  <= '0;
            dropped <= 1'b0;
        end else begin
            status  <= status_d;
            cur_id  <= id_d;
            dropped <= dropped | drop_now;
        end
    end
endmodule

// File: rtl/pme_root_status.sv
// Module: pme_root_status
// Root status register for power-management events: reports one event,
// queues later ones, re-delivers on write-1-to-clear, raises irq.
// Assumes: reg_rdata is read combinationally; writes take effect at the edge.
module pme_root_status
    import pme_pkg::*;
#(
    parameter int HOLD_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pme_valid,
    input  logic [ID_W-1:0]  pme_req_id,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq,
    output logic             pme_drop_seen
);
    logic            q_push, q_pop, q_empty, q_full;
    logic [ID_W-1:0] q_head, cur_id;
    logic            status;
    logic            clr_req;
    logic            unused_wbits;

    // Decode the write-1-to-clear request; other write bits are ignored.
    always_comb begin
        clr_req      = reg_wr_en && reg_wdata[STS_BIT];
        unused_wbits = ^{reg_wdata[REG_W-1:STS_BIT+1], reg_wdata[STS_BIT-1:0]};
    end

    pme_hold_fifo #(.W(ID_W), .DEPTH(HOLD_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .pop   (q_pop),
        .din   (pme_req_id),
        .dout  (q_head),
        .empty (q_empty),
        .full  (q_full)
    );

    pme_report_ctrl #(.W(ID_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (pme_valid),
        .evt_id    (pme_req_id),
        .clr_req   (clr_req),
        .q_empty   (q_empty),
        .q_full    (q_full),
        .q_head    (q_head),
        .q_push    (q_push),
        .q_pop     (q_pop),
        .status    (status),
        .cur_id    (cur_id),
        .dropped   (pme_drop_seen)
    );

    // Assemble the register view and the interrupt.
    always_comb begin
        reg_rdata = {{RSVD_W{1'b0}}, !q_empty, status, cur_id};
        irq       = status;
    end
endmodule

// File: rtl/pme_root_status_chk.sv
// Module: pme_root_status_chk
// Port-level properties of the event root status register, bound to the top.
// Assumes: synchronous active-low reset.
module pme_root_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pme_valid,
    input logic [15:0] pme_req_id,
    input logic        reg_wr_en,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        irq,
    input logic        pme_drop_seen
);
    logic clr_w;
    assign clr_w = reg_wr_en && reg_wdata[16];

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31:18] == 14'd0);

    a_r3_report_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[16] && pme_valid) |=> (reg_rdata[16] && reg_rdata[15:0] == $past(pme_req_id)));

    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[16] && !reg_rdata[17] && clr_w && !pme_valid) |=> !reg_rdata[16]);

    a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[16] && !clr_w) |=> reg_rdata[16]);

    a_r5_id_held: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[16] && !clr_w) |=> $stable(reg_rdata[15:0]));

    a_r6_pend_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[17] |-> reg_rdata[16]);

    a_r8_drop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        pme_drop_seen |=> pme_drop_seen);

    a_r9_direct_report: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[16] && !reg_rdata[17] && clr_w && pme_valid)
            |=> (reg_rdata[16] && reg_rdata[15:0] == $past(pme_req_id)));

    a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        irq == reg_rdata[16]);
endmodule

bind pme_root_status pme_root_status_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pme_valid     (pme_valid),
    .pme_req_id    (pme_req_id),
    .reg_wr_en     (reg_wr_en),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .irq           (irq),
    .pme_drop_seen (pme_drop_seen)
);

// File: tb/test_pme_root_status.sv
`timescale 1ns/1ps
module test_pme_root_status;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        pme_valid;
    logic [15:0] pme_req_id;
    logic        reg_wr_en;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        pme_drop_seen;

    int total = 0;
    int fails = 0;

    localparam logic [31:0] CLR = 32'h0001_0000;

    always #10 clk = ~clk;

    pme_root_status i_pme_root_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .pme_valid     (pme_valid),
        .pme_req_id    (pme_req_id),
        .reg_wr_en     (reg_wr_en),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .irq           (irq),
        .pme_drop_seen (pme_drop_seen)
    );

    function automatic logic [31:0] view(input logic sts, input logic pend, input logic [15:0] id);
        return {14'd0, pend, sts, id};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle of stimulus from a negedge; returns at the next negedge.
    task automatic cyc(input logic pv, input logic [15:0] id, input logic wr, input logic [31:0] wd);
        pme_valid  = pv;
        pme_req_id = id;
        reg_wr_en  = wr;
        reg_wdata  = wd;
        @(negedge clk);
        pme_valid = 1'b0;
        reg_wr_en = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 20);
        total++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        pme_valid = 1'b0; pme_req_id = '0; reg_wr_en = 1'b0; reg_wdata = '0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset reg", reg_rdata, 32'h0);
        chk("R1 reset irq", {31'd0, irq}, 32'h0);
        chk("R1 reset drop", {31'd0, pme_drop_seen}, 32'h0);
        rst_n = 1'b1;

        // R2: writing reserved bits while idle has no effect
        cyc(1'b0, 16'h0, 1'b1, 32'hFFFC_0000);
        chk("R2 reserved write idle", reg_rdata, 32'h0);

        // Sweep of 0..6 back-to-back arrivals, then drain.
        for (int n = 0; n <= 6; n++) begin
            logic [15:0] base;
            int held;
            base = 16'h1000 + 16'(n * 16);
            do_reset();
            for (int k = 0; k < n; k++) begin
                int h;
                cyc(1'b1, base + 16'(k), 1'b0, '0);
                h = (k > 4) ? 4 : k;
                chk(k == 0 ? "R3 first report" : "R5/R6 held arrival",
                    reg_rdata, view(1'b1, h > 0, base));
                chk("R8 drop flag", {31'd0, pme_drop_seen}, {31'd0, k > 4});
                chk("R10 irq", {31'd0, irq}, 32'd1);
            end
            held = (n == 0) ? 0 : ((n - 1 > 4) ? 4 : n - 1);
            // R4 / R2: writing 0 to status and 1 to reserved bits changes nothing
            cyc(1'b0, 16'h0, 1'b1, 32'hFFFE_FFFF);
            chk("R4 write zero no effect", reg_rdata, view(n > 0, held > 0, n > 0 ? base : 16'h0));
            for (int d = 1; d <= held; d++) begin
                cyc(1'b0, 16'h0, 1'b1, CLR);
                chk("R7 ordered delivery", reg_rdata, view(1'b1, d < held, base + 16'(d)));
            end
            cyc(1'b0, 16'h0, 1'b1, CLR);
            chk("R4 final clear", reg_rdata, view(1'b0, 1'b0, n > 0 ? base + 16'(held) : 16'h0));
            chk("R10 irq low", {31'd0, irq}, 32'd0);
            chk("R8 drop sticky", {31'd0, pme_drop_seen}, {31'd0, n > 5});
        end

        // R9: clear and new event together with nothing held
        do_reset();
        cyc(1'b1, 16'hA001, 1'b0, '0);
        cyc(1'b1, 16'hA002, 1'b1, CLR);
        chk("R9 direct report", reg_rdata, view(1'b1, 1'b0, 16'hA002));
        cyc(1'b0, 16'h0, 1'b1, CLR);
        chk("R9 then clear", reg_rdata, view(1'b0, 1'b0, 16'hA002));

        // R11: clear and new event together with two held
        do_reset();
        cyc(1'b1, 16'hB000, 1'b0, '0);
        cyc(1'b1, 16'hB001, 1'b0, '0);
        cyc(1'b1, 16'hB002, 1'b0, '0);
        cyc(1'b1, 16'hB003, 1'b1, CLR);
        chk("R11 partial head", reg_rdata, view(1'b1, 1'b1, 16'hB001));
        cyc(1'b0, 16'h0, 1'b1, CLR);
        chk("R11 partial second", reg_rdata, view(1'b1, 1'b1, 16'hB002));
        cyc(1'b0, 16'h0, 1'b1, CLR);
        chk("R11 partial appended", reg_rdata, view(1'b1, 1'b0, 16'hB003));
        cyc(1'b0, 16'h0, 1'b1, CLR);
        chk("R11 partial drained", reg_rdata, view(1'b0, 1'b0, 16'hB003));

        // R11: clear and new event together with a full queue
        do_reset();
        for (int k = 0; k < 5; k++) cyc(1'b1, 16'hC000 + 16'(k), 1'b0, '0);
        chk("R8 queue full no drop", {31'd0, pme_drop_seen}, 32'd0);
        cyc(1'b1, 16'hC005, 1'b1, CLR);
        chk("R11 full head", reg_rdata, view(1'b1, 1'b1, 16'hC001));
        chk("R11 full accepted", {31'd0, pme_drop_seen}, 32'd0);
        for (int d = 2; d <= 5; d++) begin
            cyc(1'b0, 16'h0, 1'b1, CLR);
            chk("R11 full order", reg_rdata, view(1'b1, d < 5, 16'hC000 + 16'(d)));
        end
        cyc(1'b0, 16'h0, 1'b1, CLR);
        chk("R11 full drained", reg_rdata, view(1'b0, 1'b0, 16'hC005));

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule